// File: doc/BRIEF.md
# Floating-point and vector context dirty-state tracker

This block holds the two-bit context status fields that tell an operating system whether the floating-point state and the vector state must be saved on a context switch. Each field is Off, Initial, Clean or Dirty. Dirty means the unit's registers or control and flag CSRs may have changed since the last save. The block watches one retired-instruction event per unit and moves the field to Dirty when the selected policy says so. It then keeps it Dirty until software rewrites the machine status CSR.

The precise policy marks Dirty only when the contents actually change. Three pessimistic policies mark it earlier. One marks it when the instruction is able to raise exception flags. One marks it on every instruction of the unit. One marks it when the instruction produces a flag bit, even if that bit was already set. Marking early is always safe: the only cost is an unneeded save and restore. A reduced-state option keeps only Off and Dirty. A unit that is not present has its field tied to Off. A read-only summary bit reports that either field is Dirty.

Top module: `ctx_status_tracker`

## Requirements
- R1: During and right after synchronous reset, both fields read Off (0) and the summary bit reads 0.
- R2: State encoding is Off=0, Initial=1, Clean=2, Dirty=3. With full states and the unit present, a CSR write stores the written value, and it is visible in the cycle after the write.
- R3: In reduced-state mode, a CSR write of Initial (1) or Clean (2) is stored as Dirty (3). Off and Dirty are stored as written. The field never holds 1 or 2.
- R4: A field whose unit is absent always reads Off (0), whatever writes or events arrive.
- R5: Precise policy (0): a retired instruction moves a non-Off field to Dirty only if its state-changed bit is set.
- R6: Could-flag policy (1): a retired instruction moves a non-Off field to Dirty if it changed state, or if it is able to raise flags even though it raised none.
- R7: Any-instruction policy (2): every retired instruction of the unit moves a non-Off field to Dirty.
- R8: Flag-produced policy (3): a retired instruction moves a non-Off field to Dirty if it changed state or produced a flag bit, even when no flag value changed.
- R9: Once Dirty, no instruction event leaves Dirty. Only a CSR write changes it.
- R10: A field at Off is left at Off by every instruction event.
- R11: When a CSR write and an instruction event land in the same cycle, the written value wins.
- R12: The summary bit is 1 exactly when either field reads Dirty.
- R13: The flag, could-flag and changed bits have no effect when the retire strobe of that unit is low. The vector field applies the same policy to the vector events that the FP field applies to the FP events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_retire | input | 1 | An FP instruction retires this cycle |
| fp_can_flag | input | 1 | That instruction is able to raise exception flags |
| fp_flag_raised | input | 1 | That instruction produced at least one flag bit |
| fp_state_changed | input | 1 | That instruction altered FP registers or FP CSR contents |
| vec_retire | input | 1 | A vector instruction retires this cycle |
| vec_can_flag | input | 1 | That instruction is able to raise flags |
| vec_flag_raised | input | 1 | That instruction produced a flag bit |
| vec_state_changed | input | 1 | That instruction altered vector state |
| csr_wr_en | input | 1 | Software writes the status CSR |
| csr_wr_fs | input | 2 | Written FP field value |
| csr_wr_vs | input | 2 | Written vector field value |
| fs_o | output | 2 | Current FP context field |
| vs_o | output | 2 | Current vector context field |
| sd_o | output | 1 | Either field is Dirty |

## Verification
The bench runs six copies side by side: one for each policy, one in reduced-state mode and one with the FP unit absent. Each copy is placed in every start state and then given all sixteen combinations of event bits, and its outputs are compared with a parallel model. The sweep targets several faults. A policy that ignores the could-flag or flag-produced bit leaves the field Clean where it should be Dirty. An event that is not gated by the retire strobe dirties the field spuriously. A field that leaves Off, or drops out of Dirty, on an event shows up as a wrong read. Writes issued together with events catch a design that lets the event override the software write. Reduced and absent copies catch a field that stores Initial or Clean, or that accepts writes to a missing unit.

// File: rtl/ctx_status_pkg.sv
package ctx_status_pkg;

    localparam int unsigned CTX_W = 2;

    typedef enum logic [CTX_W-1:0] {
        CTX_OFF   = 2'd0,
        CTX_INIT  = 2'd1,
        CTX_CLEAN = 2'd2,
        CTX_DIRTY = 2'd3
    } ctx_state_e;

    typedef enum logic [1:0] {
        POL_PRECISE    = 2'd0,
        POL_CAN_FLAG   = 2'd1,
        POL_ANY_OP     = 2'd2,
        POL_FLAG_MADE  = 2'd3
    } dirty_policy_e;

    typedef struct packed {
        logic retire;
        logic can_flag;
        logic flag_raised;
        logic changed;
    } ctx_event_t;

    // Value stored on a software write, honouring the reduced-state option.
    function automatic ctx_state_e csr_store(input logic reduced, input logic [CTX_W-1:0] val);
        if (reduced && (val == CTX_INIT || val == CTX_CLEAN))
            return CTX_DIRTY;
        return ctx_state_e'(val);
    endfunction

endpackage

// File: rtl/ctx_dirty_policy.sv
module ctx_dirty_policy
    import ctx_status_pkg::*;
#(
    parameter dirty_policy_e POLICY = POL_PRECISE
) (
    input  ctx_event_t ev,
    output logic       mark_dirty
);
    logic hit;

    generate
        if (POLICY == POL_PRECISE) begin : g_precise
            assign hit = ev.changed;
        end else if (POLICY == POL_CAN_FLAG) begin : g_can_flag
            assign hit = ev.changed | ev.can_flag;
        end else if (POLICY == POL_ANY_OP) begin : g_any_op
            assign hit = 1'b1;
        end else begin : g_flag_made
            assign hit = ev.changed | ev.flag_raised;
        end
    endgenerate

    assign mark_dirty = ev.retire & hit;
endmodule

// File: rtl/ctx_field.sv
module ctx_field
    import ctx_status_pkg::*;
#(
    parameter bit            PRESENT = 1'b1,
    parameter bit            REDUCED = 1'b0,
    parameter dirty_policy_e POLICY  = POL_PRECISE
) (
    input  logic             clk,
    input  logic             rst,
    input  ctx_event_t       ev,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_val,
    output ctx_state_e       state
);
    generate
        if (PRESENT) begin : g_present
            logic       mark;
            ctx_state_e state_q;
            ctx_state_e state_d;

            ctx_dirty_policy #(.POLICY(POLICY)) u_policy (
                .ev        (ev),
                .mark_dirty(mark)
            );

            always_comb begin
                state_d = state_q;
                if (wr_en)
                    state_d = csr_store(REDUCED, wr_val);
                else if (mark && state_q != CTX_OFF)
                    state_d = CTX_DIRTY;
            end

            always_ff @(posedge clk) begin
                if (rst) state_q <= CTX_OFF;
                else     state_q <= state_d;
            end

            assign state = state_q;

            assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
                (state_q == CTX_DIRTY && !wr_en) |=> state_q == CTX_DIRTY);

            assert_off_hold_R10: assert property (@(posedge clk) disable iff (rst)
                (state_q == CTX_OFF && !wr_en) |=> state_q == CTX_OFF);

            assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
                (!ev.retire && !wr_en) |=> $stable(state_q));

            if (REDUCED) begin : g_red_chk
                assert_two_state_R3: assert property (@(posedge clk) disable iff (rst)
                    state_q == CTX_OFF || state_q == CTX_DIRTY);
            end else begin : g_full_chk
                assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
                    wr_en |=> state_q == ctx_state_e'($past(wr_val)));
            end
        end else begin : g_absent
            assign state = CTX_OFF;
        end
    endgenerate
endmodule

// File: rtl/ctx_status_tracker.sv
module ctx_status_tracker
    import ctx_status_pkg::*;
#(
    parameter bit            FP_PRESENT  = 1'b1,
    parameter bit            VEC_PRESENT = 1'b1,
    parameter bit            REDUCED     = 1'b0,
    parameter dirty_policy_e POLICY      = POL_PRECISE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fp_retire,
    input  logic             fp_can_flag,
    input  logic             fp_flag_raised,
    input  logic             fp_state_changed,
    input  logic             vec_retire,
    input  logic             vec_can_flag,
    input  logic             vec_flag_raised,
    input  logic             vec_state_changed,
    input  logic             csr_wr_en,
    input  logic [CTX_W-1:0] csr_wr_fs,
    input  logic [CTX_W-1:0] csr_wr_vs,
    output logic [CTX_W-1:0] fs_o,
    output logic [CTX_W-1:0] vs_o,
    output logic             sd_o
);
    localparam int unsigned NFIELD = 2;
    localparam bit [NFIELD-1:0] PRESENT_MAP = {VEC_PRESENT, FP_PRESENT};

    ctx_event_t       ev     [NFIELD];
    logic [CTX_W-1:0] wr_val [NFIELD];
    ctx_state_e       st     [NFIELD];

    assign ev[0]     = '{retire: fp_retire, can_flag: fp_can_flag,
                         flag_raised: fp_flag_raised, changed: fp_state_changed};
    assign ev[1]     = '{retire: vec_retire, can_flag: vec_can_flag,
                         flag_raised: vec_flag_raised, changed: vec_state_changed};
    assign wr_val[0] = csr_wr_fs;
    assign wr_val[1] = csr_wr_vs;

    generate
        for (genvar i = 0; i < NFIELD; i++) begin : g_field
            ctx_field #(
                .PRESENT(PRESENT_MAP[i]),
                .REDUCED(REDUCED),
                .POLICY (POLICY)
            ) u_field (
                .clk   (clk),
                .rst   (rst),
                .ev    (ev[i]),
                .wr_en (csr_wr_en),
                .wr_val(wr_val[i]),
                .state (st[i])
            );
        end
    endgenerate

    assign fs_o = st[0];
    assign vs_o = st[1];
    assign sd_o = (st[0] == CTX_DIRTY) || (st[1] == CTX_DIRTY);

    assert_summary_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (sd_o && !csr_wr_en) |=> sd_o);

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> (fs_o == CTX_OFF && vs_o == CTX_OFF && !sd_o));
endmodule

// File: tb/ctx_status_tracker_bench.sv
`timescale 1ns/1ps
module ctx_status_tracker_bench;
    import ctx_status_pkg::*;

    localparam int NCFG = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] fp_ev = '0;
    logic [3:0] vec_ev = '0;
    logic we = 1'b0;
    logic [1:0] wfs = '0, wvs = '0;

    logic [1:0] fs_w [NCFG];
    logic [1:0] vs_w [NCFG];
    logic       sd_w [NCFG];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    function automatic int cfg_pol(int i);
        return (i < 4) ? i : ((i == 4) ? 2 : 0);
    endfunction

    generate
        for (genvar i = 0; i < NCFG; i++) begin : g_dut
            ctx_status_tracker #(
                .FP_PRESENT (i != 5),
                .VEC_PRESENT(1'b1),
                .REDUCED    (i == 4),
                .POLICY     (dirty_policy_e'(cfg_pol(i)))
            ) u_ctx_status_tracker (
                .clk(clk), .rst(rst),
                .fp_retire(fp_ev[3]), .fp_can_flag(fp_ev[2]),
                .fp_flag_raised(fp_ev[1]), .fp_state_changed(fp_ev[0]),
                .vec_retire(vec_ev[3]), .vec_can_flag(vec_ev[2]),
                .vec_flag_raised(vec_ev[1]), .vec_state_changed(vec_ev[0]),
                .csr_wr_en(we), .csr_wr_fs(wfs), .csr_wr_vs(wvs),
                .fs_o(fs_w[i]), .vs_o(vs_w[i]), .sd_o(sd_w[i])
            );
        end
    endgenerate

    logic [1:0] exp_fs [NCFG];
    logic [1:0] exp_vs [NCFG];

    function automatic logic [1:0] ref_next(int pol, bit red, bit pres, logic [1:0] cur,
                                            bit wen, logic [1:0] wv, logic [3:0] e);
        bit hit;
        if (!pres) return 2'd0;
        if (wen) return (red && (wv == 2'd1 || wv == 2'd2)) ? 2'd3 : wv;
        if (cur == 2'd0 || !e[3]) return cur;
        case (pol)
            0: hit = e[0];
            1: hit = e[0] | e[2];
            2: hit = 1'b1;
            default: hit = e[0] | e[1];
        endcase
        return hit ? 2'd3 : cur;
    endfunction

    function automatic string tag_of(int pol, bit red, bit pres, logic [1:0] cur,
                                     bit wen, logic [3:0] e);
        if (!pres) return "R4";
        if (wen) return e[3] ? "R11" : (red ? "R3" : "R2");
        if (!e[3]) return "R13";
        if (cur == 2'd0) return "R10";
        if (cur == 2'd3) return "R9";
        case (pol)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, int i, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cfg%0d %s: actual %0d expected %0d", tag, i, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, update the model, check after the edge.
    task automatic step(bit wen, logic [1:0] f, logic [1:0] v, logic [3:0] fe, logic [3:0] ve);
        string tf [NCFG];
        string tv [NCFG];
        we = wen; wfs = f; wvs = v; fp_ev = fe; vec_ev = ve;
        for (int i = 0; i < NCFG; i++) begin
            tf[i] = tag_of(cfg_pol(i), i == 4, i != 5, exp_fs[i], wen, fe);
            tv[i] = tag_of(cfg_pol(i), i == 4, 1'b1, exp_vs[i], wen, ve);
            exp_fs[i] = ref_next(cfg_pol(i), i == 4, i != 5, exp_fs[i], wen, f, fe);
            exp_vs[i] = ref_next(cfg_pol(i), i == 4, 1'b1, exp_vs[i], wen, v, ve);
        end
        @(negedge clk);
        for (int i = 0; i < NCFG; i++) begin
            check(tf[i], "fs", i, fs_w[i], exp_fs[i]);
            check(tv[i], "vs", i, vs_w[i], exp_vs[i]);
            check("R12", "sd", i, {1'b0, sd_w[i]},
                  {1'b0, (exp_fs[i] == 2'd3) || (exp_vs[i] == 2'd3)});
        end
    endtask

    initial begin
        for (int i = 0; i < NCFG; i++) begin exp_fs[i] = 2'd0; exp_vs[i] = 2'd0; end
        repeat (3) @(negedge clk);
        for (int i = 0; i < NCFG; i++) begin
            check("R1", "fs", i, fs_w[i], 2'd0);
            check("R1", "vs", i, vs_w[i], 2'd0);
            check("R1", "sd", i, {1'b0, sd_w[i]}, 2'd0);
        end
        rst = 1'b0;
        // Every start state against every event combination, both units.
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b1, 2'(s), 2'(3 - s), 4'h0, 4'h0);
                step(1'b0, 2'd0, 2'd0, 4'(c), 4'(c) ^ 4'b0110);
            end
        end
        // Software write together with an instruction event: write wins.
        for (int s = 0; s < 4; s++) begin
            step(1'b1, 2'(s), 2'(s), 4'hF, 4'hF);
            step(1'b1, 2'(s), 2'(3 - s), 4'b1001, 4'b1100);
        end
        // Repeated events on Dirty, then write Clean back.
        step(1'b1, 2'd3, 2'd3, 4'h0, 4'h0);
        step(1'b0, 2'd0, 2'd0, 4'hF, 4'h8);
        step(1'b1, 2'd2, 2'd2, 4'h0, 4'h0);
        step(1'b0, 2'd0, 2'd0, 4'h0, 4'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule